// File: doc/BRIEF.md
# Processor Request Issue Flow Controller

This block decides which of a processor's waiting bus requests goes out next on a multiplexed system bus. Each request takes a single address cycle. Five request sources feed it: read, write, null write, invalidate and update. Each source holds its request and its address until the block acknowledges it. In the cycle after the acknowledge, the block drives one registered address cycle with a valid strobe, a 3-bit command and the address.

An external agent throttles traffic with two active-low ready lines. One line governs the read class: reads, invalidates and ordinary updates. The other governs writes. Two kinds of request ignore flow control on purpose. A null write is always taken at once. An update raised while a read is outstanding is a potential update, and it goes out whatever the read-ready line says.

The block also tracks the one read it allows to be outstanding. That read stays pending until the agent delivers its last response word. The response may arrive long after the request, with other bus activity in between. A response word flagged as erroneous raises a bus-error pulse.

Top module: `preq_issue_ctrl`

## Requirements
- R1: A read, an invalidate or an update issued while no read is pending is acknowledged only if `rd_rdy_n` was low in the previous clock cycle.
- R2: A write is acknowledged only if `wr_rdy_n` was low in the previous clock cycle.
- R3: A null write is acknowledged in the same cycle it is requested, whatever the state of either ready input and whatever other requests are present.
- R4: An update requested while `read_pending` is high is issued with command 3'b101, even when `rd_rdy_n` is high. An update issued with no read pending carries command 3'b100.
- R5: `read_pending` rises in the cycle the read's address cycle appears on the bus. It stays high through response words with `resp_last` low. It is low in the cycle after a word with `resp_valid` and `resp_last` both high.
- R6: While a read is pending, no further read is acknowledged.
- R7: When several requests are eligible, the one acknowledged follows a fixed priority. Null write comes first, then potential update, then read, then invalidate, then ordinary update, then write.
- R8: At most one request is acknowledged per cycle. An acknowledged request appears in the next cycle on `bus_valid`, `bus_cmd` and `bus_addr`, for exactly one cycle. The commands are read 3'b000, write 3'b001, null write 3'b010, invalidate 3'b011, update 3'b100 and potential update 3'b101. With no issue, `bus_valid`, `bus_cmd` and `bus_addr` are all zero.
- R9: A response word with `resp_err` high that arrives while a read is pending makes `bus_error` high for exactly the next cycle. Response words that arrive with no read pending have no effect on `bus_error` or on `read_pending`.
- R10: During reset and in the first cycle after it, nothing but a null write can be acknowledged. While reset is held, `bus_valid` and `read_pending` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_rdy_n | input | 1 | Agent can take read-class requests (active low) |
| wr_rdy_n | input | 1 | Agent can take write requests (active low) |
| rd_req | input | 1 | Read request held until acknowledged |
| rd_addr | input | AW | Read address |
| rd_ack | output | 1 | Read request taken this cycle |
| wr_req | input | 1 | Write request |
| wr_addr | input | AW | Write address |
| wr_ack | output | 1 | Write request taken |
| nw_req | input | 1 | Null write request |
| nw_addr | input | AW | Null write address |
| nw_ack | output | 1 | Null write taken |
| iv_req | input | 1 | Invalidate request |
| iv_addr | input | AW | Invalidate address |
| iv_ack | output | 1 | Invalidate taken |
| up_req | input | 1 | Update request |
| up_addr | input | AW | Update address |
| up_ack | output | 1 | Update taken (ordinary or potential) |
| resp_valid | input | 1 | Read response word present |
| resp_last | input | 1 | Word is the last of the response |
| resp_err | input | 1 | Word is flagged as erroneous |
| bus_valid | output | 1 | Address cycle strobe |
| bus_cmd | output | 3 | Command of the address cycle |
| bus_addr | output | AW | Address of the address cycle |
| read_pending | output | 1 | A read has been issued and its last word not yet received |
| bus_error | output | 1 | One-cycle pulse for an erroneous response word |

## Verification
The bench changes a ready line in the same cycle it raises a request. A design that used the live ready level instead of the sampled one would acknowledge a cycle early. The bench holds a read, a write and an update together while a read is outstanding and read-ready is high. A design that gated the potential update would stall, and one that let a second read through would emit a second read command. It also sends non-last response words, an erroneous word, and a stray response after completion. These catch a pending flag that clears early, an error pulse that is missing or too long, and an error raised with no read outstanding. Priority is probed by presenting several requests at once, including a null write while the write-ready line is high.

// File: rtl/preq_pkg.sv
package preq_pkg;

    typedef enum logic [2:0] {
        CMD_READ   = 3'b000,
        CMD_WRITE  = 3'b001,
        CMD_NULLW  = 3'b010,
        CMD_INVAL  = 3'b011,
        CMD_UPDATE = 3'b100,
        CMD_POTUPD = 3'b101
    } cmd_e;

    // Arbitration slots, lowest index wins
    localparam int NSLOT     = 6;
    localparam int SL_NULLW  = 0;
    localparam int SL_POTUPD = 1;
    localparam int SL_READ   = 2;
    localparam int SL_INVAL  = 3;
    localparam int SL_UPDATE = 4;
    localparam int SL_WRITE  = 5;

    function automatic cmd_e slot_cmd(input int s);
        case (s)
            SL_NULLW:  return CMD_NULLW;
            SL_POTUPD: return CMD_POTUPD;
            SL_READ:   return CMD_READ;
            SL_INVAL:  return CMD_INVAL;
            SL_UPDATE: return CMD_UPDATE;
            default:   return CMD_WRITE;
        endcase
    endfunction

endpackage

// File: rtl/preq_ready_sampler.sv
module preq_ready_sampler (
    input  logic clk,
    input  logic rst_n,
    input  logic rd_rdy_n,
    input  logic wr_rdy_n,
    output logic rd_ok,
    output logic wr_ok
);
    typedef struct packed {
        logic rd_ok;
        logic wr_ok;
    } rdy_t;

    rdy_t rdy_d, rdy_q;

    always_comb begin
        rdy_d       = rdy_q;
        rdy_d.rd_ok = ~rd_rdy_n;
        rdy_d.wr_ok = ~wr_rdy_n;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rdy_q <= '0;
        else        rdy_q <= rdy_d;
    end

    assign rd_ok = rdy_q.rd_ok;
    assign wr_ok = rdy_q.wr_ok;

endmodule

// File: rtl/preq_arbiter.sv
module preq_arbiter
    import preq_pkg::*;
(
    input  logic             nw_req,
    input  logic             up_req,
    input  logic             rd_req,
    input  logic             iv_req,
    input  logic             wr_req,
    input  logic             rd_ok,
    input  logic             wr_ok,
    input  logic             pend,
    output logic [NSLOT-1:0] grant
);
    logic [NSLOT-1:0] elig;
    logic [NSLOT:0]   taken;

    always_comb begin
        elig            = '0;
        elig[SL_NULLW]  = nw_req;
        elig[SL_POTUPD] = up_req & pend;
        elig[SL_READ]   = rd_req & rd_ok & ~pend;
        elig[SL_INVAL]  = iv_req & rd_ok;
        elig[SL_UPDATE] = up_req & rd_ok & ~pend;
        elig[SL_WRITE]  = wr_req & wr_ok;
    end

    assign taken[0] = 1'b0;

    for (genvar i = 0; i < NSLOT; i++) begin : g_prio
        assign grant[i]   = elig[i] & ~taken[i];
        assign taken[i+1] = taken[i] | elig[i];
    end

endmodule

// File: rtl/preq_read_tracker.sv
module preq_read_tracker (
    input  logic clk,
    input  logic rst_n,
    input  logic rd_issue,
    input  logic resp_valid,
    input  logic resp_last,
    input  logic resp_err,
    output logic pending,
    output logic bus_error
);
    typedef struct packed {
        logic pend;
        logic err;
    } trk_t;

    trk_t trk_d, trk_q;

    always_comb begin
        trk_d     = trk_q;
        trk_d.err = trk_q.pend & resp_valid & resp_err;
        if (rd_issue)
            trk_d.pend = 1'b1;
        else if (trk_q.pend && resp_valid && resp_last)
            trk_d.pend = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) trk_q <= '0;
        else        trk_q <= trk_d;
    end

    assign pending   = trk_q.pend;
    assign bus_error = trk_q.err;

    // R5: a last word ends the pending read
    assert_last_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (pending && resp_valid && resp_last) |=> !pending);

    // R9: an error pulse always traces back to a flagged word during a pending read
    assert_err_source_R9: assert property (@(posedge clk) disable iff (!rst_n)
        bus_error |-> $past(resp_valid && resp_err && pending));

    // R9: error pulse lasts one cycle unless another flagged word arrives
    assert_err_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_error && !(resp_valid && resp_err)) |=> !bus_error);

endmodule

// File: rtl/preq_issue_ctrl.sv
module preq_issue_ctrl
    import preq_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_rdy_n,
    input  logic          wr_rdy_n,
    input  logic          rd_req,
    input  logic [AW-1:0] rd_addr,
    output logic          rd_ack,
    input  logic          wr_req,
    input  logic [AW-1:0] wr_addr,
    output logic          wr_ack,
    input  logic          nw_req,
    input  logic [AW-1:0] nw_addr,
    output logic          nw_ack,
    input  logic          iv_req,
    input  logic [AW-1:0] iv_addr,
    output logic          iv_ack,
    input  logic          up_req,
    input  logic [AW-1:0] up_addr,
    output logic          up_ack,
    input  logic          resp_valid,
    input  logic          resp_last,
    input  logic          resp_err,
    output logic          bus_valid,
    output logic [2:0]    bus_cmd,
    output logic [AW-1:0] bus_addr,
    output logic          read_pending,
    output logic          bus_error
);
    typedef struct packed {
        logic          valid;
        cmd_e          cmd;
        logic [AW-1:0] addr;
    } bus_t;

    logic             rd_ok, wr_ok;
    logic [NSLOT-1:0] grant;
    logic [AW-1:0]    slot_addr [NSLOT];
    bus_t             bus_d, bus_q;

    preq_ready_sampler u_rdy (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_rdy_n (rd_rdy_n),
        .wr_rdy_n (wr_rdy_n),
        .rd_ok    (rd_ok),
        .wr_ok    (wr_ok)
    );

    preq_arbiter u_arb (
        .nw_req (nw_req),
        .up_req (up_req),
        .rd_req (rd_req),
        .iv_req (iv_req),
        .wr_req (wr_req),
        .rd_ok  (rd_ok),
        .wr_ok  (wr_ok),
        .pend   (read_pending),
        .grant  (grant)
    );

    preq_read_tracker u_trk (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_issue   (grant[SL_READ]),
        .resp_valid (resp_valid),
        .resp_last  (resp_last),
        .resp_err   (resp_err),
        .pending    (read_pending),
        .bus_error  (bus_error)
    );

    assign slot_addr[SL_NULLW]  = nw_addr;
    assign slot_addr[SL_POTUPD] = up_addr;
    assign slot_addr[SL_READ]   = rd_addr;
    assign slot_addr[SL_INVAL]  = iv_addr;
    assign slot_addr[SL_UPDATE] = up_addr;
    assign slot_addr[SL_WRITE]  = wr_addr;

    assign nw_ack = grant[SL_NULLW];
    assign rd_ack = grant[SL_READ];
    assign iv_ack = grant[SL_INVAL];
    assign wr_ack = grant[SL_WRITE];
    assign up_ack = grant[SL_POTUPD] | grant[SL_UPDATE];

    always_comb begin
        bus_d = '0;
        for (int i = 0; i < NSLOT; i++) begin
            if (grant[i]) begin
                bus_d.valid = 1'b1;
                bus_d.cmd   = slot_cmd(i);
                bus_d.addr  = slot_addr[i];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) bus_q <= '0;
        else        bus_q <= bus_d;
    end

    assign bus_valid = bus_q.valid;
    assign bus_cmd   = bus_q.cmd;
    assign bus_addr  = bus_q.addr;

    // R1: read-class issue (other than potential update) needs read-ready seen low a cycle earlier
    assert_rd_gate_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_ack || iv_ack || (up_ack && !read_pending)) |-> $past(!rd_rdy_n));

    // R2: write issue needs write-ready seen low a cycle earlier
    assert_wr_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ack |-> $past(!wr_rdy_n));

    // R3: null write is never held back
    assert_nullw_bypass_R3: assert property (@(posedge clk) disable iff (!rst_n)
        nw_req |-> nw_ack);

    // R4: update during a pending read is taken unless a null write is present
    assert_potupd_bypass_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (up_req && read_pending && !nw_req) |-> up_ack);

    // R6: a single read outstanding
    assert_one_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ack |-> !read_pending);

    // R8: one acknowledge per cycle
    assert_one_ack_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rd_ack, wr_ack, nw_ack, iv_ack, up_ack}));

    // R8: acknowledge is followed by exactly one address cycle
    assert_ack_issue_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_ack || wr_ack || nw_ack || iv_ack || up_ack) |=> bus_valid);

    assert_idle_bus_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_ack || wr_ack || nw_ack || iv_ack || up_ack) |=> !bus_valid);

endmodule

// File: tb/sim_preq_issue_ctrl.sv
module sim_preq_issue_ctrl;

    localparam int AW = 32;
    localparam logic [AW-1:0] A_RD = 32'h100, A_WR = 32'h200, A_NW = 32'h300,
                              A_IV = 32'h400, A_UP = 32'h500;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rd_rdy_n = 1'b1, wr_rdy_n = 1'b1;
    logic rd_req = 0, wr_req = 0, nw_req = 0, iv_req = 0, up_req = 0;
    logic rd_ack, wr_ack, nw_ack, iv_ack, up_ack;
    logic resp_valid = 0, resp_last = 0, resp_err = 0;
    logic bus_valid, read_pending, bus_error;
    logic [2:0] bus_cmd;
    logic [AW-1:0] bus_addr;

    int n_chk = 0;
    int n_err = 0;
    bit done = 0;

    always #4 clk = ~clk;

    preq_issue_ctrl #(.AW(AW)) u0 (
        .clk(clk), .rst_n(rst_n), .rd_rdy_n(rd_rdy_n), .wr_rdy_n(wr_rdy_n),
        .rd_req(rd_req), .rd_addr(A_RD), .rd_ack(rd_ack),
        .wr_req(wr_req), .wr_addr(A_WR), .wr_ack(wr_ack),
        .nw_req(nw_req), .nw_addr(A_NW), .nw_ack(nw_ack),
        .iv_req(iv_req), .iv_addr(A_IV), .iv_ack(iv_ack),
        .up_req(up_req), .up_addr(A_UP), .up_ack(up_ack),
        .resp_valid(resp_valid), .resp_last(resp_last), .resp_err(resp_err),
        .bus_valid(bus_valid), .bus_cmd(bus_cmd), .bus_addr(bus_addr),
        .read_pending(read_pending), .bus_error(bus_error)
    );

    // fields: ready lines, requests {nw,up,iv,wr,rd}, expected acks, valid, cmd, pending
    typedef struct packed {
        logic       rd_rdy_n;
        logic       wr_rdy_n;
        logic [4:0] req;
        logic [4:0] ack;
        logic       valid;
        logic [2:0] cmd;
        logic       pend;
    } vec_t;

    localparam vec_t VEC [0:10] = '{
        '{1'b1, 1'b1, 5'b01111, 5'b00000, 1'b0, 3'b000, 1'b0}, // R1 R2 nothing ready
        '{1'b0, 1'b0, 5'b00011, 5'b00000, 1'b0, 3'b000, 1'b0}, // R1 R2 ready not yet sampled
        '{1'b0, 1'b0, 5'b00111, 5'b00001, 1'b1, 3'b000, 1'b1}, // R7 read first, R5 pending
        '{1'b0, 1'b0, 5'b00111, 5'b00100, 1'b1, 3'b011, 1'b1}, // R6 read blocked, invalidate
        '{1'b1, 1'b0, 5'b01011, 5'b01000, 1'b1, 3'b101, 1'b1}, // R4 potential update
        '{1'b1, 1'b0, 5'b01011, 5'b01000, 1'b1, 3'b101, 1'b1}, // R4 ignores read-ready high
        '{1'b1, 1'b0, 5'b00011, 5'b00010, 1'b1, 3'b001, 1'b1}, // R2 write
        '{1'b1, 1'b1, 5'b10010, 5'b10000, 1'b1, 3'b010, 1'b1}, // R3 null write over write
        '{1'b1, 1'b1, 5'b11010, 5'b10000, 1'b1, 3'b010, 1'b1}, // R3 R7 null write over potupd
        '{1'b1, 1'b1, 5'b00010, 5'b00000, 1'b0, 3'b000, 1'b1}, // R2 write-ready high
        '{1'b1, 1'b1, 5'b00100, 5'b00000, 1'b0, 3'b000, 1'b1}  // R1 read-ready high
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic set_req(input logic [4:0] r);
        {nw_req, up_req, iv_req, wr_req, rd_req} = r;
    endtask

    function automatic logic [31:0] addr_of(input logic valid, input logic [2:0] c);
        if (!valid) return 32'h0;
        case (c)
            3'b000: return A_RD;
            3'b001: return A_WR;
            3'b010: return A_NW;
            3'b011: return A_IV;
            default: return A_UP;
        endcase
    endfunction

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R10 reset bus_valid", 32'(bus_valid), 0);
        chk("R10 reset read_pending", 32'(read_pending), 0);
        rst_n = 1'b1;

        // table walk
        for (int v = 0; v <= 10; v++) begin
            rd_rdy_n = VEC[v].rd_rdy_n;
            wr_rdy_n = VEC[v].wr_rdy_n;
            set_req(VEC[v].req);
            #1;
            chk($sformatf("R7 vec %0d acks", v),
                32'({nw_ack, up_ack, iv_ack, wr_ack, rd_ack}), 32'(VEC[v].ack));
            step();
            chk($sformatf("R8 vec %0d valid/cmd", v),
                32'({bus_valid, bus_cmd}), 32'({VEC[v].valid, VEC[v].cmd}));
            chk($sformatf("R8 vec %0d addr", v), bus_addr, addr_of(VEC[v].valid, VEC[v].cmd));
            chk($sformatf("R5 vec %0d pending", v), 32'(read_pending), 32'(VEC[v].pend));
        end
        set_req(5'b0);

        // R5: non-last word keeps the read pending
        resp_valid = 1; resp_last = 0; resp_err = 0;
        step();
        chk("R5 pending after non-last word", 32'(read_pending), 1);
        chk("R9 no error on clean word", 32'(bus_error), 0);

        // R9: flagged word gives a one-cycle pulse
        resp_err = 1;
        step();
        chk("R9 error pulse", 32'(bus_error), 1);
        resp_valid = 0; resp_err = 0;
        step();
        chk("R9 error pulse ends", 32'(bus_error), 0);

        // R5: last word ends the read
        resp_valid = 1; resp_last = 1;
        step();
        chk("R5 pending cleared", 32'(read_pending), 0);

        // R9: stray response with nothing pending
        resp_err = 1;
        step();
        chk("R9 stray error ignored", 32'(bus_error), 0);
        chk("R9 stray word leaves pending low", 32'(read_pending), 0);
        resp_valid = 0; resp_last = 0; resp_err = 0;

        // R1 / R7: update and invalidate with read-ready just lowered
        rd_rdy_n = 0; iv_req = 1; up_req = 1;
        #1;
        chk("R1 no ack before ready sampled", 32'({iv_ack, up_ack}), 0);
        step();
        #1;
        chk("R7 invalidate over update", 32'({iv_ack, up_ack}), 32'b10);
        step();
        chk("R8 invalidate cmd", 32'(bus_cmd), 3);
        iv_req = 0;
        #1;
        chk("R4 plain update acked", 32'(up_ack), 1);
        step();
        chk("R4 plain update cmd", 32'(bus_cmd), 4);
        chk("R8 update addr", bus_addr, A_UP);
        up_req = 0;

        // R6: held read is taken once
        rd_req = 1;
        #1;
        chk("R6 first read acked", 32'(rd_ack), 1);
        step();
        chk("R5 pending on read issue", 32'(read_pending), 1);
        #1;
        chk("R6 second read blocked", 32'(rd_ack), 0);
        step();
        chk("R8 bus idle while blocked", 32'(bus_valid), 0);

        // R10: reset mid-run with requests held
        rst_n = 0;
        step();
        chk("R10 pending cleared in reset", 32'(read_pending), 0);
        chk("R10 bus idle in reset", 32'(bus_valid), 0);
        rst_n = 1;
        #1;
        chk("R10 no read ack right after reset", 32'(rd_ack), 0);
        step();
        #1;
        chk("R10 read ack once ready sampled", 32'(rd_ack), 1);
        step();
        rd_req = 0;

        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule